// File: doc/BRIEF.md
# Register-Pointer Two-Wire Target

This block is the target side of a two-wire serial bus (I2C) in front of a small byte-wide register array. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. It decodes a 7-bit device address set by a parameter, followed by a direction bit, and answers only when the address is its own. The data line is driven open-drain. The block has one output that, when high, pulls the bus low. The bus pull-up and the wired-AND are outside the block.

A write transfer carries a pointer byte and then zero or more data bytes. The pointer byte places the internal pointer, and each data byte is stored at the pointer, which then steps by one. A read transfer returns bytes starting at the pointer and keeps going while the controller acknowledges. The pointer is not cleared between transfers. This means a read with no pointer byte before it picks up where the last transfer left off. It also means a write of the pointer followed by a repeated START and a read returns data from the pointer just set.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START condition (data falling while the clock is high) is recognised in any state and begins address reception. A STOP condition (data rising while the clock is high) returns the block to idle with the data line released.
- R2: The first byte after START is sent MSB first: seven address bits, then a direction bit (0 = write, 1 = read). When the seven bits equal DEV_ADDR, the block pulls the data line low for the ninth clock.
- R3: On an address mismatch the block gives no acknowledge and keeps the data line released. It ignores all later bytes, and stores nothing, until the next START or STOP.
- R4: In a write transfer, the first byte after the address is acknowledged and loads the pointer with its value modulo DEPTH.
- R5: Every later byte of a write transfer is acknowledged and stored at the pointer, after which the pointer steps by one.
- R6: In a read transfer the block sends, MSB first, the byte at the pointer and steps the pointer. It sends a further byte after each acknowledge from the controller.
- R7: A not-acknowledge from the controller ends the read. The block then keeps the data line released until the next START.
- R8: The pointer keeps its value across transfers. It steps from DEPTH-1 to 0.
- R9: Data is sampled on the rising clock edge. The driven data line changes only while the clock is low.
- R10: A repeated START resets the bit position and returns the block to address reception without changing the pointer.
- R11: After reset the data line is released, the pointer is 0 and every register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (after the wired-AND) |
| sdaDrvLow | output | 1 | When high, the pin pulls the data line low |

## Verification
A wrong pointer cannot be seen directly. It first appears as a wrong byte in the next read, which can be a whole transfer later, so every write is followed at some point by a read that relies on the persisted pointer. A wrong bit count or state shows within nine bus clocks, as an acknowledge in the wrong bit slot or as a driven bit where the controller expects a released line. A wrong address decision shows at the first acknowledge slot. Mismatched transfers are therefore followed by reads that prove the registers were left untouched.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting in address + direction
    ST_RX,     // shifting in pointer or data byte
    ST_ACK,    // target acknowledge slot
    ST_TX,     // shifting out a data byte
    ST_MACK    // controller acknowledge slot
  } busState_t;

  typedef struct packed {
    logic bitIn;      // synchronised data line
    logic shiftIn;    // take bitIn into receive shifter
    logic setPtr;     // load pointer from received byte
    logic writeByte;  // store received byte at pointer, step pointer
    logic loadTx;     // fetch byte at pointer, drive its MSB, step pointer
    logic shiftTx;    // drive next transmit bit
    logic ackOn;      // pull data low for acknowledge
    logic relSda;     // release data line
  } strobe_t;

endpackage

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxNext,
  input  logic       drvLow,
  output strobe_t    strb
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sclQ, sdaQ;
  logic sclP, sdaP;
  logic sclS, sdaS;
  logic sclRise, sclFall, startC, stopC;

  busState_t state;
  logic [2:0] bitCnt;
  logic ackPhase, rwBit, gotPtr;

  assign sclS    = sclQ[SYNC_STAGES-1];
  assign sdaS    = sdaQ[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startC  = sclS & sclP & sdaP & ~sdaS;
  assign stopC   = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclQ <= {sclQ[SYNC_STAGES-2:0], sclIn};
      sdaQ <= {sdaQ[SYNC_STAGES-2:0], sdaIn};
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  always_comb begin
    strb = '0;
    strb.bitIn = sdaS;
    if (startC || stopC) begin
      strb.relSda = 1'b1;
    end else begin
      case (state)
        ST_ADDR: strb.shiftIn = sclRise;
        ST_RX: begin
          strb.shiftIn = sclRise;
          if (sclRise && bitCnt == 3'd7) begin
            strb.writeByte = gotPtr;
            strb.setPtr    = ~gotPtr;
          end
        end
        ST_ACK: if (sclFall) begin
          if (!ackPhase)  strb.ackOn  = 1'b1;
          else if (rwBit) strb.loadTx = 1'b1;
          else            strb.relSda = 1'b1;
        end
        ST_TX:   strb.shiftTx = sclFall;
        ST_MACK: if (sclFall) begin
          if (!ackPhase) strb.relSda = 1'b1;
          else           strb.loadTx = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      rwBit    <= 1'b0;
      gotPtr   <= 1'b0;
    end else if (startC) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      gotPtr   <= 1'b0;
    end else if (stopC) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            if (rxNext[7:1] == DEV_ADDR) begin
              state    <= ST_ACK;
              rwBit    <= rxNext[0];
              ackPhase <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_RX: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            state    <= ST_ACK;
            ackPhase <= 1'b0;
            gotPtr   <= 1'b1;
          end
        end
        ST_ACK: if (sclFall) begin
          if (!ackPhase) begin
            ackPhase <= 1'b1;
          end else begin
            ackPhase <= 1'b0;
            bitCnt   <= '0;
            state    <= rwBit ? ST_TX : ST_RX;
          end
        end
        ST_TX: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            state    <= ST_MACK;
            ackPhase <= 1'b0;
          end
        end
        ST_MACK: begin
          if (sclFall && !ackPhase) begin
            ackPhase <= 1'b1;
          end else if (sclRise && ackPhase && sdaS) begin
            state <= ST_IDLE;
          end else if (sclFall && ackPhase) begin
            state    <= ST_TX;
            bitCnt   <= '0;
            ackPhase <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1 / R10: any START restarts address reception at bit 0
  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rstN)
    startC |=> (state == ST_ADDR && bitCnt == 3'd0));

  // R1: STOP leaves the block idle with the line released by the datapath
  assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopC |=> (state == ST_IDLE && !drvLow));

  // R3 / R7: no drive while idle, ignoring or receiving
  assert_quiet_unless_sending_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_ADDR || state == ST_RX) |-> !drvLow);

  // R2: acknowledge slot is actually pulled low by the datapath
  assert_ack_driven_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && ackPhase) |-> drvLow);

endmodule

// File: rtl/i2c_reg_dpath.sv
module i2c_reg_dpath
  import i2c_reg_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  output logic [7:0] rxNext,
  output logic       drvLow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [7:0] rxShift, txShift;
  logic [PTR_W-1:0] ptr, ptrStep;
  logic [DEPTH-1:0][7:0] mem;

  assign rxNext  = {rxShift[6:0], strb.bitIn};
  assign ptrStep = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
      drvLow  <= 1'b0;
      mem     <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= rxNext;
      if (strb.setPtr)  ptr     <= PTR_W'(rxNext % DEPTH);
      if (strb.writeByte) begin
        mem[ptr] <= rxNext;
        ptr      <= ptrStep;
      end
      if (strb.loadTx) begin
        txShift <= mem[ptr];
        ptr     <= ptrStep;
      end
      if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};

      if (strb.relSda)       drvLow <= 1'b0;
      else if (strb.ackOn)   drvLow <= 1'b1;
      else if (strb.loadTx)  drvLow <= ~mem[ptr][7];
      else if (strb.shiftTx) drvLow <= ~txShift[6];
    end
  end

  // R8: the pointer only moves on a load, a store or a fetch
  assert_ptr_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setPtr || strb.writeByte || strb.loadTx) |=> $stable(ptr));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         DEPTH    = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDrvLow
);

  strobe_t    strb;
  logic [7:0] rxNext;

  i2c_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxNext (rxNext),
    .drvLow (sdaDrvLow),
    .strb   (strb)
  );

  i2c_reg_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rxNext (rxNext),
    .drvLow (sdaDrvLow)
  );

  // R9: the driven line moves only while the bus clock is low
  assert_drive_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclIn);

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int DEPTH      = 16;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaDrvLow;
  logic busSda;

  assign busSda = mSda & ~sdaDrvLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) i_i2c_reg_slave (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (mScl),
    .sdaIn     (busSda),
    .sdaDrvLow (sdaDrvLow)
  );

  int checks = 0;
  int failures = 0;
  int r9Viol = 0;
  logic [7:0] model [DEPTH];
  int mPtr = 0;
  logic prevDrv = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9 monitor: driven line must not move while the bus clock is high
  always @(negedge clk) begin
    if (rstN && (sdaDrvLow !== prevDrv) && mScl) r9Viol++;
    prevDrv = sdaDrvLow;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitXfer(input logic d, output logic s);
    mSda = d;
    waitQ();
    mScl = 1'b1;
    waitQ();
    s = busSda;
    mScl = 1'b0;
    waitQ();
  endtask

  task automatic mStart();
    if (!mScl) begin
      mSda = 1'b1;
      waitQ();
      mScl = 1'b1;
      waitQ();
    end
    mSda = 1'b0;
    waitQ();
    mScl = 1'b0;
    waitQ();
  endtask

  task automatic mStop();
    mSda = 1'b0;
    waitQ();
    mScl = 1'b1;
    waitQ();
    mSda = 1'b1;
    waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitXfer(b[i], s);
    bitXfer(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b1, s);
      b[i] = s;
    end
    bitXfer(~ackIt, s);
  endtask

  function automatic logic [7:0] addrByte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  function automatic int stepPtr(input int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic readBody(input int n);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      check(b == model[mPtr], "R6/R8 read byte at pointer", int'(b), int'(model[mPtr]));
      mPtr = stepPtr(mPtr);
    end
  endtask

  task automatic writeHead(input int p);
    logic ack;
    mStart();
    sendByte(addrByte(DEV, 1'b0), ack);
    check(ack, "R2 write address ack", int'(ack), 1);
    sendByte(8'(p), ack);
    check(ack, "R4 pointer byte ack", int'(ack), 1);
    mPtr = p % DEPTH;
  endtask

  task automatic doWrite(input int p, input int n);
    logic ack;
    logic [7:0] d;
    writeHead(p);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, ack);
      check(ack, "R5 data byte ack", int'(ack), 1);
      model[mPtr] = d;
      mPtr = stepPtr(mPtr);
    end
    mStop();
  endtask

  task automatic doRead(input int n);
    logic ack;
    mStart();
    sendByte(addrByte(DEV, 1'b1), ack);
    check(ack, "R2 read address ack", int'(ack), 1);
    readBody(n);
    mStop();
  endtask

  task automatic doCombined(input int p, input int n);
    logic ack;
    writeHead(p);
    mStart();  // repeated START, R10: pointer must survive
    sendByte(addrByte(DEV, 1'b1), ack);
    check(ack, "R10 address ack after repeated start", int'(ack), 1);
    readBody(n);
    mStop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

    repeat (5) @(negedge clk);
    check(sdaDrvLow == 1'b0, "R11 released during reset", int'(sdaDrvLow), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(sdaDrvLow == 1'b0, "R11 released after reset", int'(sdaDrvLow), 0);

    // R11: pointer 0 and zeroed registers
    doRead(3);

    // R5/R8: write then a read with no pointer byte continues
    doWrite(5, 4);
    doRead(2);

    // R8: wrap from the last register to the first
    doWrite(DEPTH - 1, 2);
    doCombined(DEPTH - 1, 2);

    // R3: wrong address, no ack, nothing stored
    mStart();
    sendByte(addrByte(DEV ^ 7'h01, 1'b0), ack);
    check(!ack, "R3 mismatched address not acked", int'(ack), 0);
    sendByte(8'h03, ack);
    check(!ack, "R3 later byte ignored", int'(ack), 0);
    sendByte(8'h5A, ack);
    check(!ack, "R3 data ignored", int'(ack), 0);
    mStop();
    doCombined(3, 2);

    // R3: wrong address for a read, line stays released
    mStart();
    sendByte(addrByte(DEV ^ 7'h40, 1'b1), ack);
    check(!ack, "R3 mismatched read not acked", int'(ack), 0);
    recvByte(1'b0, b);
    check(b == 8'hFF, "R3 no data driven", int'(b), 8'hFF);
    mStop();

    // R7: NACK ends the read, next byte slot stays released
    mStart();
    sendByte(addrByte(DEV, 1'b1), ack);
    check(ack, "R2 read address ack", int'(ack), 1);
    recvByte(1'b0, b);
    check(b == model[mPtr], "R6 single read byte", int'(b), int'(model[mPtr]));
    mPtr = stepPtr(mPtr);
    recvByte(1'b0, b);
    check(b == 8'hFF, "R7 released after NACK", int'(b), 8'hFF);
    mStop();
    doRead(1);  // R8 pointer advanced by exactly one

    // R4: high bits of pointer byte are dropped modulo DEPTH
    doWrite(8'hF3, 1);
    doCombined(8'hF3, 1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      case ($urandom_range(2, 0))
        0: doWrite(int'($urandom_range(255, 0)), int'($urandom_range(4, 0)));
        1: doRead(int'($urandom_range(4, 1)));
        default: doCombined(int'($urandom_range(255, 0)), int'($urandom_range(4, 1)));
      endcase
    end

    check(r9Viol == 0, "R9 drive changed with clock high", r9Viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule